// File: doc/BRIEF.md
# Cache Block Refill Sequencer

After a cache miss, this block brings one whole block in from the next memory level and writes it into the data array. The cache controller hands it a block number and the way chosen for replacement. Read misses and write misses both allocate, so both arrive as the same request. The sequencer then raises a single read towards the lower level. The lower level has no data-valid strobe, so the sequencer counts cycles itself. It waits a fixed lead latency for the first 8-byte beat, then a shorter fixed gap before each further beat. As each beat arrives it is written into the selected way at the next word offset.

A 64-byte block moves as eight beats. The first beat lands 7 cycles after the read is issued and each later beat lands 2 cycles after the one before. A one-cycle completion pulse follows the eighth write, and the controller may commit the tag and valid bit only on that pulse. While a refill is running the sequencer refuses new requests. Reset drops any block that has only partly arrived.

Top module: `refill_seq`

## Requirements
- R1: After reset the sequencer is idle: `req_ready` is 1 and `mem_rd_valid`, `wr_en` and `done` are 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) makes `mem_rd_valid` 1 for exactly the next cycle, with `mem_rd_blk` equal to the accepted `req_blk`.
- R3: The first array write (`wr_en` = 1) occurs 7 cycles after the cycle in which `mem_rd_valid` was 1, and `wr_en` stays 0 before it.
- R4: Each later write occurs 2 cycles after the previous one, and `wr_en` is 0 in the cycles between writes.
- R5: A refill performs exactly 8 writes. `wr_word` runs 0,1,...,7 in that order. `wr_data` equals `mem_data` in the same cycle. `wr_way` and `wr_blk` hold the way and block number of the accepted request.
- R6: `done` is 1 for exactly one cycle, the cycle right after the eighth write. In the cycle after that, `req_ready` is 1 again.
- R7: From the cycle after acceptance through the `done` cycle, `req_ready` is 0. Any request held during that time is neither taken nor causes another read. It is taken only once `req_ready` returns to 1.
- R8: Asserting reset part-way through a refill abandons it. No further writes, read or `done` follow, and the sequencer is idle with `req_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request from the cache controller |
| req_ready | output | 1 | High when idle and able to accept a request |
| req_blk | input | 26 | Block number (address with the block offset removed) |
| req_way | input | 2 | Way to be filled |
| mem_rd_valid | output | 1 | One-cycle read command to the lower level |
| mem_rd_blk | output | 26 | Block number of the read |
| mem_data | input | 64 | Beat data from the lower level, valid on fixed cycles |
| wr_en | output | 1 | Data array write strobe |
| wr_way | output | 2 | Way being written |
| wr_blk | output | 26 | Block number being written |
| wr_word | output | 3 | Word offset of the beat within the block |
| wr_data | output | 64 | Beat data to write |
| done | output | 1 | One-cycle pulse after the last beat has been written |

## Verification
A wrong cycle counter shows at the ports as a write in the wrong cycle. A bad lead count is visible at the first beat, 7 cycles after the read. A bad gap count is visible within 2 cycles of any beat, and the bench also catches it because `wr_data` is then sampled while the lower level drives filler instead of a real beat. A wrong beat counter shows up as a wrong `wr_word`, a write count other than eight, or a `done` pulse too early or too late, all within the 22 cycles of one refill. A state that stays busy or wakes up wrongly after reset is seen at once on `req_ready`, or as a stray write or read.

// File: rtl/refill_seq.sv
module refill_seq #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int BLK_BYTES = 64,
  parameter int WAYS      = 4,
  parameter int LEAD      = 7,
  parameter int GAP       = 2,
  localparam int BEATS    = BLK_BYTES / (DATA_W / 8),
  localparam int OFF      = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFF,
  localparam int WORD_W   = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CNT_W    = $clog2(LEAD + GAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BLK_W-1:0]  req_blk,
  input  logic [WAY_W-1:0]  req_way,
  output logic              mem_rd_valid,
  output logic [BLK_W-1:0]  mem_rd_blk,
  input  logic [DATA_W-1:0] mem_data,
  output logic              wr_en,
  output logic [WAY_W-1:0]  wr_way,
  output logic [BLK_W-1:0]  wr_blk,
  output logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT, FIN} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] beat;
  logic [BLK_W-1:0]  blk;
  logic [WAY_W-1:0]  way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cnt  <= '0;
      beat <= '0;
      blk  <= '0;
      way  <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          blk <= req_blk;
          way <= req_way;
          st  <= ISSUE;
        end
        ISSUE: begin
          cnt  <= CNT_W'(LEAD - 1);
          beat <= '0;
          st   <= WAIT;
        end
        WAIT: begin
          if (cnt == '0) begin
            if (beat == WORD_W'(BEATS - 1)) st <= FIN;
            else begin
              beat <= beat + 1'b1;
              cnt  <= CNT_W'(GAP - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign req_ready    = (st == IDLE);
  assign mem_rd_valid = (st == ISSUE);
  assign mem_rd_blk   = blk;
  assign wr_en        = (st == WAIT) && (cnt == '0);
  assign wr_way       = way;
  assign wr_blk       = blk;
  assign wr_word      = beat;
  assign wr_data      = mem_data;
  assign done         = (st == FIN);

endmodule

// File: rtl/refill_seq_chk.sv
module refill_seq_chk #(
  parameter int LEAD   = 7,
  parameter int GAP    = 2,
  parameter int BEATS  = 8,
  parameter int WORD_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd_valid,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_word,
  input logic              done
);

  logic        active;
  logic [15:0] since;
  logic [15:0] nbeat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      since  <= '0;
      nbeat  <= '0;
    end else if (mem_rd_valid) begin
      active <= 1'b1;
      since  <= 16'd1;
      nbeat  <= '0;
    end else if (active) begin
      since <= since + 16'd1;
      if (wr_en) nbeat <= nbeat + 16'd1;
      if (done) active <= 1'b0;
    end
  end

  a_r1_ready_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !mem_rd_valid) |-> req_ready);

  a_r2_read_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_rd_valid);

  a_r2_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  a_r3_beat_timing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (active && 32'(since) == LEAD + GAP * 32'(nbeat)));

  a_r5_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_word) == 32'(nbeat) && 32'(nbeat) < BEATS));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (active && 32'(nbeat) == BEATS && $past(wr_en)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  a_r7_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (active || mem_rd_valid) |-> !req_ready);

endmodule

bind refill_seq refill_seq_chk #(
  .LEAD(LEAD), .GAP(GAP), .BEATS(BEATS), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd_valid(mem_rd_valid), .wr_en(wr_en), .wr_word(wr_word), .done(done)
);

// File: tb/tb_refill_seq.sv
`timescale 1ns/1ps
module tb_refill_seq;
  localparam int BLK_W = 26;
  localparam int WAY_W = 2;
  localparam int LEAD  = 7;
  localparam int GAP   = 2;
  localparam int BEATS = 8;
  localparam int LAST  = LEAD + GAP * (BEATS - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [BLK_W-1:0] req_blk = '0;
  logic [WAY_W-1:0] req_way = '0;
  logic [63:0] mem_data = '0;
  logic req_ready, mem_rd_valid, wr_en, done;
  logic [BLK_W-1:0] mem_rd_blk, wr_blk;
  logic [WAY_W-1:0] wr_way;
  logic [2:0] wr_word;
  logic [63:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  refill_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .req_way(req_way), .mem_rd_valid(mem_rd_valid),
    .mem_rd_blk(mem_rd_blk), .mem_data(mem_data), .wr_en(wr_en),
    .wr_way(wr_way), .wr_blk(wr_blk), .wr_word(wr_word), .wr_data(wr_data),
    .done(done)
  );

  function automatic logic [63:0] pat(input logic [BLK_W-1:0] b, input int k);
    return (64'(b) * 64'h9E3779B97F4A7C15) ^ (64'(k + 1) * 64'h0101010101010101);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    chk(req_ready === 1'b1, req, 64'(req_ready), 64'd1);
    chk(mem_rd_valid === 1'b0, req, 64'(mem_rd_valid), 64'd0);
    chk(wr_en === 1'b0, req, 64'(wr_en), 64'd0);
    chk(done === 1'b0, req, 64'(done), 64'd0);
  endtask

  // pend: request already accepted at the previous edge. hold: keep a new request up while busy.
  task automatic refill(input logic [WAY_W-1:0] way, input logic [BLK_W-1:0] blk,
                        input bit pend, input bit hold, input logic [BLK_W-1:0] nblk);
    if (!pend) begin
      @(negedge clk);
      req_valid = 1'b1; req_blk = blk; req_way = way;
      #1;
      while (req_ready !== 1'b1) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    req_valid = hold; req_blk = nblk; req_way = ~way;
    mem_data = ~pat(blk, 0);
    #1;
    chk(mem_rd_valid === 1'b1, "R2", 64'(mem_rd_valid), 64'd1);
    chk(mem_rd_blk === blk, "R2", 64'(mem_rd_blk), 64'(blk));
    for (int t = 1; t <= LAST + 2; t++) begin
      @(negedge clk);
      begin
        bit is_beat;
        int k;
        is_beat = (t >= LEAD) && (t <= LAST) && (((t - LEAD) % GAP) == 0);
        k = (t - LEAD) / GAP;
        mem_data = is_beat ? pat(blk, k) : ~pat(blk, t);
        #1;
        chk(mem_rd_valid === 1'b0, "R7", 64'(mem_rd_valid), 64'd0);
        if (t < LEAD)
          chk(wr_en === 1'b0, "R3", 64'(wr_en), 64'd0);
        else
          chk(wr_en === is_beat, is_beat ? "R3" : "R4", 64'(wr_en), 64'(is_beat));
        if (is_beat) begin
          chk(wr_word === 3'(k), "R5", 64'(wr_word), 64'(k));
          chk(wr_data === pat(blk, k), "R5", wr_data, pat(blk, k));
          chk(wr_way === way, "R5", 64'(wr_way), 64'(way));
          chk(wr_blk === blk, "R5", 64'(wr_blk), 64'(blk));
        end
        if (t <= LAST + 1) begin
          chk(req_ready === 1'b0, "R7", 64'(req_ready), 64'd0);
          chk(done === (t == LAST + 1), "R6", 64'(done), 64'(t == LAST + 1));
        end else begin
          chk(done === 1'b0, "R6", 64'(done), 64'd0);
          chk(req_ready === 1'b1, "R6", 64'(req_ready), 64'd1);
        end
      end
    end
    if (!hold) req_valid = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk); #1;
    check_idle("R1");

    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++)
        refill(WAY_W'(w), BLK_W'(b * 26'h0AB_CDE + w), 1'b0, 1'b0, '0);

    // R7: request held during a refill is taken only afterwards
    refill(2'd1, 26'h3FF_FFFF, 1'b0, 1'b1, 26'h155_5555);
    refill(2'd2, 26'h155_5555, 1'b1, 1'b0, '0);

    // R8: reset part-way through a refill
    @(negedge clk);
    req_valid = 1'b1; req_blk = 26'h0123_456; req_way = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < LAST + 5; i++) begin
      @(negedge clk); #1;
      check_idle("R8");
    end
    refill(2'd0, 26'h2AA_AAAA, 1'b0, 1'b0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule